// File: doc/BRIEF.md
# Timer Channel Edge-Select Capture and Polarity Output Stage

This block is one channel of a general-purpose timer. A mode input sets the direction of the channel. In capture mode, the channel watches a single input signal that has already been synchronised. A two-bit polarity code chooses which transitions count as events. Each event that is allowed through copies a free-running counter value into a capture register. It also sets sticky status flags, and software clears these flags by writing one.

In compare-output mode, the channel takes a reference waveform from a compare unit outside the block. It then drives a pin value and a pin-enable. A polarity bit can invert the pin value, and an enable bit can turn the pin off. A registered configuration-error output reports polarity settings that must not be used.

The counter, the input filter, the prescaler, the encoder and slave logic, and the register bus are all outside this block. All configuration arrives on plain input ports.

Top module: `cc_chan_pol`

## Requirements
- R1: In capture mode (`cap_mode`=1), with `pol_sec`=0 and `pol_pri`=0, only a low-to-high transition of `sig_in` is an active event.
- R2: In capture mode, with `pol_sec`=0 and `pol_pri`=1, only a high-to-low transition of `sig_in` is an active event.
- R3: In capture mode, with `pol_sec`=1 and `pol_pri`=1, both transitions of `sig_in` are active events.
- R4: In capture mode, the code `pol_sec`=1 with `pol_pri`=0 never produces a capture. While the channel is in capture mode with this code, `cfg_err` is 1 from the next clock on.
- R5: `cfg_err` is also 1 from the next clock on in two other cases: capture mode with code 11 while `enc_mode`=1, and compare-output mode with `pol_sec`=1. In every other case `cfg_err` is 0.
- R6: In capture mode with `chan_en`=0, a transition that would otherwise be active does not cause a capture, and `cap_val` and the flags keep their values.
- R7: A transition is seen at the clock edge where the sampled `sig_in` first differs from its previous sample. The capture takes place at the following clock edge and loads the `cnt_val` present at that edge into `cap_val`.
- R8: Each capture sets `cap_flag`. `cap_clr`=1 clears `cap_flag` at a clock edge where no capture happens. When a capture and a clear fall on the same edge, the capture wins.
- R9: A capture that happens while `cap_flag` is already 1 sets `ovr_flag`. `ovr_clr`=1 clears `ovr_flag` at a clock edge where no new overcapture happens, and an overcapture wins over a clear on the same edge.
- R10: In compare-output mode with `chan_en`=1, one clock later `pin_out` equals `ref_wave` XOR `pol_pri` and `pin_oe` is 1.
- R11: In compare-output mode with `chan_en`=0, and at all times in capture mode, `pin_out` and `pin_oe` are 0 one clock later.
- R12: A synchronous active-high `rst` sets `cap_val`, `cap_flag`, `ovr_flag`, `pin_out`, `pin_oe` and `cfg_err` to 0. It also clears the stored input sample, so a high `sig_in` at the first edge after reset counts as a rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_mode | input | 1 | 1 = capture mode, 0 = compare-output mode |
| chan_en | input | 1 | Capture enable (capture mode) or pin enable (output mode) |
| pol_pri | input | 1 | Primary polarity bit |
| pol_sec | input | 1 | Secondary polarity bit |
| enc_mode | input | 1 | Set when the channel feeds an encoder |
| sig_in | input | 1 | Synchronised input signal |
| cnt_val | input | CNT_W | Free-running counter value |
| ref_wave | input | 1 | Reference waveform from the compare unit |
| cap_clr | input | 1 | Write-one-to-clear for `cap_flag` |
| ovr_clr | input | 1 | Write-one-to-clear for `ovr_flag` |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |
| pin_out | output | 1 | Output pin value |
| pin_oe | output | 1 | Output pin enable |
| cfg_err | output | 1 | Forbidden polarity configuration |

## Verification
The assertions assume three things about the inputs:
- `sig_in` is already synchronous to `clk`.
- All inputs are stable around each rising edge.
- `rst` is held at least one edge from time zero.

The stimulus keeps to these assumptions by changing every input only on the falling edge and by starting in reset. Within a phase, the mode and polarity stay fixed while `sig_in`, `cnt_val`, `ref_wave` and the clears change at random. Extra phases change the enable and the encoder flag on their own, so that events dropped by gating and error reporting are covered apart from the edge choice.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RSVD = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_code_e;

  // Event test for one sampled pair (current, previous) under a code.
  function automatic logic edge_active(input edge_code_e code,
                                       input logic cur,
                                       input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (code)
      EDGE_RISE: edge_active = rise;
      EDGE_FALL: edge_active = fall;
      EDGE_BOTH: edge_active = rise | fall;
      default:   edge_active = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cc_edge_sense.sv
module cc_edge_sense
  import cc_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_in,
  input  logic [1:0] code_in,
  input  logic       arm_in,
  output logic       hit_o
);

  edge_code_e code;
  logic       sig_q;
  logic       hit_q;
  logic       act;

  assign code = edge_code_e'(code_in);
  assign act  = edge_active(code, sig_in, sig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      sig_q <= sig_in;
      hit_q <= act & arm_in;
    end
  end

  assign hit_o = hit_q;

  // R4: the reserved code never yields an event
  a_r4_rsvd_no_hit: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> ($past(code_in) != 2'b10));

  // R6: an event needs the channel armed
  a_r6_hit_needs_arm: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(arm_in));

  // R7: an event needs a change of the sampled input
  a_r7_hit_needs_change: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> ($past(sig_in) != $past(sig_q)));

endmodule

// File: rtl/cc_capture_bank.sv
module cc_capture_bank #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_clr,
  input  logic             ovr_clr,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             ovr_o
);

  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  logic             ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (hit_i) begin
        cap_q  <= cnt_i;
        flag_q <= 1'b1;
      end else if (cap_clr) begin
        flag_q <= 1'b0;
      end
      if (hit_i && flag_q) begin
        ovr_q <= 1'b1;
      end else if (ovr_clr) begin
        ovr_q <= 1'b0;
      end
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;

  // R7: the counter at the event edge lands in the register
  a_r7_cap_value: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (cap_q == $past(cnt_i)));

  // R8: capture sets the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_q);

  // R9: second capture on a set flag raises overcapture
  a_r9_ovr_set: assert property (@(posedge clk) disable iff (rst)
    (hit_i && flag_q) |=> ovr_q);

  // R6: with no event the captured value holds
  a_r6_value_holds: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(cap_q));

endmodule

// File: rtl/cc_drive_stage.sv
module cc_drive_stage (
  input  logic clk,
  input  logic rst,
  input  logic out_mode,
  input  logic en_in,
  input  logic inv_in,
  input  logic ref_in,
  output logic pin_o,
  output logic oe_o
);

  logic pin_q;
  logic oe_q;
  logic drive;

  assign drive = out_mode & en_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= drive;
      pin_q <= drive ? (ref_in ^ inv_in) : 1'b0;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;

  // R11: a disabled pin is driven low
  a_r11_off_low: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> !pin_q);

  // R10: enable is only granted in output mode
  a_r10_oe_mode: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(out_mode));

endmodule

// File: rtl/cc_cfg_guard.sv
module cc_cfg_guard
  import cc_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_mode,
  input  logic [1:0] code_in,
  input  logic       enc_mode,
  output logic       err_o
);

  edge_code_e code;
  logic       bad;
  logic       err_q;

  assign code = edge_code_e'(code_in);

  always_comb begin
    if (cap_mode) begin
      bad = (code == EDGE_RSVD) || ((code == EDGE_BOTH) && enc_mode);
    end else begin
      bad = code_in[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad;
  end

  assign err_o = err_q;

  // R5: a clean rising-edge capture setup never reports an error
  a_r5_clean_cfg: assert property (@(posedge clk) disable iff (rst)
    (cap_mode && code_in == 2'b00) |=> !err_q);

endmodule

// File: rtl/cc_chan_pol.sv
module cc_chan_pol #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_mode,
  input  logic             chan_en,
  input  logic             pol_pri,
  input  logic             pol_sec,
  input  logic             enc_mode,
  input  logic             sig_in,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             ref_wave,
  input  logic             cap_clr,
  input  logic             ovr_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             cfg_err
);

  localparam int CODE_W = 2;

  logic [CODE_W-1:0] code;
  logic              arm;
  logic              hit;

  assign code = {pol_sec, pol_pri};
  assign arm  = cap_mode & chan_en;

  cc_edge_sense u_sense (
    .clk     (clk),
    .rst     (rst),
    .sig_in  (sig_in),
    .code_in (code),
    .arm_in  (arm),
    .hit_o   (hit)
  );

  cc_capture_bank #(.CNT_W(CNT_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (hit),
    .cnt_i   (cnt_val),
    .cap_clr (cap_clr),
    .ovr_clr (ovr_clr),
    .cap_o   (cap_val),
    .flag_o  (cap_flag),
    .ovr_o   (ovr_flag)
  );

  cc_drive_stage u_drive (
    .clk      (clk),
    .rst      (rst),
    .out_mode (~cap_mode),
    .en_in    (chan_en),
    .inv_in   (pol_pri),
    .ref_in   (ref_wave),
    .pin_o    (pin_out),
    .oe_o     (pin_oe)
  );

  cc_cfg_guard u_guard (
    .clk      (clk),
    .rst      (rst),
    .cap_mode (cap_mode),
    .code_in  (code),
    .enc_mode (enc_mode),
    .err_o    (cfg_err)
  );

  // R11: capture mode keeps the pin released
  a_r11_cap_mode_off: assert property (@(posedge clk) disable iff (rst)
    cap_mode |=> !pin_oe);

  // R12: reset leaves every output low
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (cap_val == '0 && !cap_flag && !ovr_flag && !pin_out && !pin_oe && !cfg_err));

endmodule

// File: tb/cc_chan_pol_tb_top.sv
module cc_chan_pol_tb_top;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_mode = 1'b1, chan_en = 1'b0, pol_pri = 1'b0, pol_sec = 1'b0;
  logic enc_mode = 1'b0, sig_in = 1'b0, ref_wave = 1'b0;
  logic cap_clr = 1'b0, ovr_clr = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic [CNT_W-1:0] cap_val;
  logic cap_flag, ovr_flag, pin_out, pin_oe, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  cc_chan_pol #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cap_mode(cap_mode), .chan_en(chan_en),
    .pol_pri(pol_pri), .pol_sec(pol_sec), .enc_mode(enc_mode),
    .sig_in(sig_in), .cnt_val(cnt_val), .ref_wave(ref_wave),
    .cap_clr(cap_clr), .ovr_clr(ovr_clr), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .pin_out(pin_out),
    .pin_oe(pin_oe), .cfg_err(cfg_err)
  );

  // Behavioural reference: event pending queue plus expected outputs.
  bit pend_q[$];
  bit prev_s = 1'b0;
  int m_cap = 0;
  bit m_cf = 0, m_of = 0, m_pin = 0, m_oe = 0, m_err = 0;
  int n_caps = 0;

  always @(posedge clk) begin
    bit ev;
    bit take;
    int code;
    if (rst) begin
      pend_q.delete();
      prev_s = 0; m_cap = 0; m_cf = 0; m_of = 0;
      m_pin = 0; m_oe = 0; m_err = 0;
    end else begin
      take = (pend_q.size() > 0) ? pend_q.pop_front() : 1'b0;
      if (take) begin
        m_of  = m_cf ? 1'b1 : (ovr_clr ? 1'b0 : m_of);
        m_cf  = 1'b1;
        m_cap = int'(cnt_val);
        n_caps++;
      end else begin
        if (ovr_clr) m_of = 1'b0;
        if (cap_clr) m_cf = 1'b0;
      end
      code = pol_sec * 2 + pol_pri;
      if (code == 0)      ev = sig_in && !prev_s;
      else if (code == 1) ev = !sig_in && prev_s;
      else if (code == 3) ev = sig_in != prev_s;
      else                ev = 1'b0;
      pend_q.push_back(ev && cap_mode && chan_en);
      prev_s = sig_in;
      m_oe  = !cap_mode && chan_en;
      m_pin = m_oe ? (ref_wave != pol_pri) : 1'b0;
      if (cap_mode) m_err = (code == 2) || (code == 3 && enc_mode);
      else          m_err = pol_sec;
    end
  end

  task automatic check_all();
    n_tests++;
    if (int'(cap_val) != m_cap || cap_flag != m_cf || ovr_flag != m_of ||
        pin_out != m_pin || pin_oe != m_oe || cfg_err != m_err) begin
      n_fail++;
      $display("FAIL %s: cap=%0h cf=%0b of=%0b pin=%0b oe=%0b err=%0b expected cap=%0h cf=%0b of=%0b pin=%0b oe=%0b err=%0b",
               cur_req, cap_val, cap_flag, ovr_flag, pin_out, pin_oe, cfg_err,
               m_cap, m_cf, m_of, m_pin, m_oe, m_err);
    end
  endtask

  task automatic run_phase(input string req, input bit mode, input bit en,
                           input bit sec, input bit pri, input bit enc,
                           input int cycles, input bit clears);
    cur_req = req;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all();
      cap_mode = mode; chan_en = en; pol_sec = sec; pol_pri = pri; enc_mode = enc;
      if (($urandom % 3) == 0) sig_in = ~sig_in;
      cnt_val  = cnt_val + CNT_W'(1 + ($urandom % 5));
      ref_wave = $urandom % 2;
      cap_clr  = clears && (($urandom % 4) == 0);
      ovr_clr  = clears && (($urandom % 6) == 0);
    end
    cap_clr = 1'b0;
    ovr_clr = 1'b0;
  endtask

  initial begin
    // R12: reset state, with sig_in high at release
    sig_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R12";
    check_all();
    rst = 1'b0;
    chan_en = 1'b1;
    n_caps = 0;
    @(negedge clk); check_all();
    @(negedge clk); check_all();
    n_tests++;
    if (n_caps != 1 || !cap_flag) begin
      n_fail++;
      $display("FAIL R12: captures after reset=%0d flag=%0b expected 1 1", n_caps, cap_flag);
    end
    // R7 directed: rising edge, capture value one clock later
    cur_req = "R7";
    sig_in = 1'b0; cap_clr = 1'b1;
    @(negedge clk); check_all();
    cap_clr = 1'b0; sig_in = 1'b1; cnt_val = 16'h1234;
    @(negedge clk); check_all();
    cnt_val = 16'h5678;
    @(negedge clk); check_all();
    n_tests++;
    if (cap_val != 16'h5678 || !cap_flag) begin
      n_fail++;
      $display("FAIL R7: cap=%0h flag=%0b expected 5678 1", cap_val, cap_flag);
    end
    run_phase("R1", 1, 1, 0, 0, 0, 200, 0);
    run_phase("R2", 1, 1, 0, 1, 0, 200, 0);
    run_phase("R3", 1, 1, 1, 1, 0, 200, 0);
    run_phase("R4", 1, 1, 1, 0, 0, 150, 1);
    run_phase("R5", 1, 1, 1, 1, 1, 150, 1);
    run_phase("R5", 0, 1, 1, 0, 0, 60, 0);
    run_phase("R6", 1, 0, 1, 1, 0, 150, 1);
    run_phase("R8", 1, 1, 1, 1, 0, 300, 1);
    run_phase("R9", 1, 1, 0, 0, 0, 300, 1);
    run_phase("R10", 0, 1, 0, 0, 0, 100, 0);
    run_phase("R10", 0, 1, 0, 1, 0, 100, 0);
    run_phase("R11", 0, 0, 0, 1, 0, 100, 0);
    run_phase("R11", 1, 1, 0, 1, 0, 60, 0);
    @(negedge clk); check_all();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog %s: run did not end, expected completion", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule